// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory holding up to 8192 bytes. A fast system clock oversamples the bus clock and data lines, finds start and stop conditions, and steps through the address and data bytes. It pulls the data line low through an open-drain enable to acknowledge bytes and to send read data. It never drives the line high.

A write header carries the five upper address bits. The byte after it supplies the lower eight. The data bytes that follow fill one 32-byte page. A read header streams bytes from an internal address counter, and a dummy write followed by a repeated start turns this into a random read. Whether a byte may be stored is decided outside the block: the block presents the target address, and a permit input answers for that address. When a write transaction has stored at least one byte, the stop that ends it starts a self-timed busy interval. During that interval the slave does not answer its address, so a master can poll until the slave responds.

The array is a behavioural register array whose depth is a parameter. Addresses wrap modulo that depth when it is smaller than 8192.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the data line is released and the slave acknowledges nothing until it has seen a start condition.
- R2: A falling data edge while the clock is high is a start, and a rising data edge while the clock is high is a stop. The slave changes its data-line drive only while the bus clock is low.
- R3: The header byte is, from bit 7 down: select-2, select-1, A10, A11, A12, A9, A8, R/W (1 = read). The slave acknowledges it on the ninth clock only when bit 7 equals the inverse of the select-2 pin, bit 6 equals the select-1 pin, and no internal write is running.
- R4: In a write, the byte after the header gives A7..A0, forming a 13-bit address with the header's upper bits. Each permitted data byte is stored there and acknowledged.
- R5: Within one write, only the low five address bits advance after each stored byte. The 33rd byte wraps to the start of the page and overwrites it.
- R6: The stop that ends a write which stored at least one byte starts a busy interval of BUSY_CYCLES clocks. During that interval headers are not acknowledged, and afterwards they are acknowledged again.
- R7: The address counter holds the exact address of the last stored byte, or the last read address plus one. A current-address read returns data from the counter and ignores the upper address bits in the read header.
- R8: A write header and address byte, followed by a repeated start and a read header, returns the data at that address.
- R9: During a read the full 13-bit counter advances after each byte and wraps from 0x1FFF to 0x0000. Each master ACK yields another byte. After a master NACK the slave leaves the line released until the next start or stop.
- R10: A data byte whose address is not permitted is neither stored nor acknowledged. A write that stores nothing starts no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired, includes own drive) |
| sel1Pin | input | 1 | Device select strap compared directly with header bit 6 |
| sel2Pin | input | 1 | Device select strap compared inverted with header bit 7 |
| writePermit | input | 1 | High when a write to permitAddr is allowed |
| permitAddr | output | 13 | Address the next data byte would be written to |
| sdaPullLow | output | 1 | Open-drain enable: high pulls the data line low |

## Verification
The hardest states to reach are the busy interval and the page wrap. Both need long, well-formed transactions built from many correctly timed bit cells. The bench has a bit-level master that emits starts, repeated starts and stops. It polls right after each storing stop, so it sees at least one refused header before the slave answers again. To wrap the page, it writes 34 bytes starting two below the end of a page. A behavioural memory and counter model predicts every acknowledge and read byte. A per-clock watch checks that the slave's drive never moves while the bus clock is high.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam int ADDR_W = 13;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_RACK
  } ctrlState_t;

  typedef struct packed {
    logic shiftRx;
    logic loadHigh;
    logic loadLow;
    logic storeByte;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sdaLevel  = sdaNow;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int PAGE_BITS = 5,
  parameter int MEM_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaLevel,
  output logic [1:0]        devSel,
  output logic              rwBit,
  output logic              txBit,
  output logic [ADDR_W-1:0] writeAddr
);

  localparam int IDX_W  = $clog2(MEM_DEPTH);
  localparam int HIGH_W = ADDR_W - 8;

  logic [7:0]           mem [MEM_DEPTH];
  logic [7:0]           rxByte;
  logic [7:0]           txShift;
  logic [HIGH_W-1:0]    highBits;
  logic [ADDR_W-1:0]    writePtr;
  logic [ADDR_W-1:0]    curAddr;
  logic [PAGE_BITS-1:0] nextLow;

  assign nextLow   = writePtr[PAGE_BITS-1:0] + PAGE_BITS'(1);
  assign devSel    = rxByte[7:6];
  assign rwBit     = rxByte[0];
  assign txBit     = txShift[7];
  assign writeAddr = writePtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txShift  <= '0;
      highBits <= '0;
      writePtr <= '0;
      curAddr  <= '0;
    end else begin
      if (strobe.shiftRx) rxByte <= {rxByte[6:0], sdaLevel};
      // header bit order: A10, A11, A12, A9, A8 in bits 5..1
      if (strobe.loadHigh) highBits <= {rxByte[3], rxByte[4], rxByte[5], rxByte[2], rxByte[1]};
      if (strobe.loadLow) begin
        writePtr <= {highBits, rxByte};
        curAddr  <= {highBits, rxByte};
      end
      if (strobe.storeByte) begin
        curAddr  <= writePtr;
        writePtr <= {writePtr[ADDR_W-1:PAGE_BITS], nextLow};
      end
      if (strobe.loadTx) begin
        txShift <= mem[curAddr[IDX_W-1:0]];
        curAddr <= curAddr + ADDR_W'(1);
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeByte) mem[writePtr[IDX_W-1:0]] <= rxByte;
  end

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int BUSY_CYCLES = 50000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      sdaLevel,
  input  logic [1:0] devSel,
  input  logic      rwBit,
  input  logic      txBit,
  input  logic      sel1Pin,
  input  logic      sel2Pin,
  input  logic      writePermit,
  output dpStrobe_t strobe,
  output logic      sdaPullLow,
  output logic      busy
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  ctrlState_t      state, stateN;
  logic [3:0]      bitCnt, bitCntN;
  logic            ackDrive, ackN;
  logic            txEn, txEnN;
  logic            isRead, readN;
  logic            masterAck, mAckN;
  logic            wroteAny, wroteN;
  logic [BUSY_W-1:0] busyCnt, busyN;
  logic            addrMatch;

  assign busy      = (busyCnt != '0);
  assign addrMatch = (devSel == {~sel2Pin, sel1Pin}) && !busy;

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    ackN    = ackDrive;
    txEnN   = txEn;
    readN   = isRead;
    mAckN   = masterAck;
    wroteN  = wroteAny;
    busyN   = busy ? busyCnt - BUSY_W'(1) : '0;
    strobe  = '0;
    if (startSeen) begin
      stateN  = ST_DEV;
      bitCntN = '0;
      ackN    = 1'b0;
      txEnN   = 1'b0;
    end else if (stopSeen) begin
      stateN = ST_IDLE;
      ackN   = 1'b0;
      txEnN  = 1'b0;
      wroteN = 1'b0;
      if (wroteAny) busyN = BUSY_W'(BUSY_CYCLES);
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            strobe.shiftRx = 1'b1;
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            stateN = ST_IDLE;
            if (state == ST_DEV) begin
              if (addrMatch) begin
                ackN            = 1'b1;
                readN           = rwBit;
                strobe.loadHigh = !rwBit;
                stateN          = ST_DEV_ACK;
              end
            end else if (state == ST_ADDR) begin
              ackN           = 1'b1;
              strobe.loadLow = 1'b1;
              stateN         = ST_ADDR_ACK;
            end else if (writePermit) begin
              ackN             = 1'b1;
              strobe.storeByte = 1'b1;
              wroteN           = 1'b1;
              stateN           = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            ackN    = 1'b0;
            bitCntN = '0;
            if (state == ST_DEV_ACK && isRead) begin
              strobe.loadTx = 1'b1;
              txEnN         = 1'b1;
              stateN        = ST_TX;
            end else if (state == ST_DEV_ACK) begin
              stateN = ST_ADDR;
            end else begin
              stateN = ST_WDATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              txEnN  = 1'b0;
              stateN = ST_RACK;
            end else begin
              strobe.shiftTx = 1'b1;
              bitCntN = bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) mAckN = ~sdaLevel;
          if (sclFall) begin
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              txEnN         = 1'b1;
              bitCntN       = '0;
              stateN        = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txEn      <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      wroteAny  <= 1'b0;
      busyCnt   <= '0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitCntN;
      ackDrive  <= ackN;
      txEn      <= txEnN;
      isRead    <= readN;
      masterAck <= mAckN;
      wroteAny  <= wroteN;
      busyCnt   <= busyN;
    end
  end

  assign sdaPullLow = ackDrive | (txEn & ~txBit);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int PAGE_BITS   = 5,
  parameter int MEM_DEPTH   = 1024,
  parameter int BUSY_CYCLES = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              sel1Pin,
  input  logic              sel2Pin,
  input  logic              writePermit,
  output logic [ADDR_W-1:0] permitAddr,
  output logic              sdaPullLow
);

  logic      sdaLevel, sclRise, sclFall, startSeen, stopSeen;
  logic [1:0] devSel;
  logic      rwBit, txBit, busyFlag;
  dpStrobe_t strobe;

  eeprom_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  eeprom_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLevel(sdaLevel),
    .devSel(devSel), .rwBit(rwBit), .txBit(txBit),
    .sel1Pin(sel1Pin), .sel2Pin(sel2Pin), .writePermit(writePermit),
    .strobe(strobe), .sdaPullLow(sdaPullLow), .busy(busyFlag)
  );

  eeprom_datapath #(.PAGE_BITS(PAGE_BITS), .MEM_DEPTH(MEM_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLevel(sdaLevel),
    .devSel(devSel), .rwBit(rwBit), .txBit(txBit), .writeAddr(permitAddr)
  );

endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker
  import eeprom_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaPullLow,
  input logic      writePermit,
  input logic      busyFlag,
  input dpStrobe_t strobe
);

  // R2: drive moves only while the bus clock has been low
  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> (!sclIn && !$past(sclIn)));

  // R6: nothing is driven during the busy interval
  assert_silent_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> !sdaPullLow);

  // R6: busy begins at a stop, with the bus clock high
  assert_busy_at_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> (sclIn && $past(sclIn)));

  // R10: a store only happens with permit and outside busy
  assert_store_permitted_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |-> (writePermit && !busyFlag));

  // R4: at most one datapath action per cycle
  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

bind serial_eeprom_slave eeprom_checker u_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .writePermit(writePermit), .busyFlag(busyFlag), .strobe(strobe)
);

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam int BUSY       = 300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mScl = 1'b1;
  logic        mSda = 1'b1;
  logic        protOn = 1'b0;
  logic        sel1Pin = 1'b1;
  logic        sel2Pin = 1'b0;
  logic        sdaLine;
  logic        writePermit;
  logic [12:0] permitAddr;
  logic        sdaPullLow;
  logic        prevPull = 1'b0;

  bit [7:0]    refMem [8192];
  int          modelCur = 0;
  int          checks = 0;
  int          failures = 0;
  int          r2Viol = 0;
  logic [7:0]  q[$];

  assign sdaLine     = mSda & ~sdaPullLow;
  assign writePermit = ~(protOn && permitAddr >= 13'h1800);

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_eeprom_slave #(.MEM_DEPTH(8192), .BUSY_CYCLES(BUSY)) u_serial_eeprom_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sel1Pin(sel1Pin), .sel2Pin(sel2Pin), .writePermit(writePermit),
    .permitAddr(permitAddr), .sdaPullLow(sdaPullLow)
  );

  // R2 per-clock watch: drive never moves while the bus clock is high
  always @(negedge clk) begin
    if (rstN && mScl && (sdaPullLow !== prevPull)) r2Viol++;
    prevPull <= sdaPullLow;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  function automatic bit permitted(input int a);
    return !(protOn && a >= 'h1800);
  endfunction

  function automatic logic [7:0] devByte(input logic [12:0] a, input logic rw);
    return {~sel2Pin, sel1Pin, a[10], a[11], a[12], a[9], a[8], rw};
  endfunction

  task automatic sendStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic sendStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    b = sdaLine;
    mScl = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    writeBit(~ackIt);
  endtask

  task automatic pollReady(input string tag);
    logic ack;
    bit   got;
    got = 0;
    sendStart(); writeByte(devByte(13'h0, 1'b0), ack); sendStop();
    check({tag, " R6 header refused right after stop"}, int'(ack), 0);
    for (int n = 0; n < 60 && !got; n++) begin
      sendStart(); writeByte(devByte(13'h0, 1'b0), ack); sendStop();
      got = ack;
    end
    check({tag, " R6 header accepted after busy"}, int'(got), 1);
  endtask

  task automatic pageWrite(input logic [12:0] addr, input logic [7:0] data[$], input string tag);
    logic ack;
    int   ptr;
    bit   stored;
    bit   expAck;
    ptr = int'(addr);
    stored = 0;
    sendStart();
    writeByte(devByte(addr, 1'b0), ack);
    check({tag, " R3 write header ack"}, int'(ack), 1);
    writeByte(addr[7:0], ack);
    check({tag, " R4 address ack"}, int'(ack), 1);
    modelCur = ptr;
    foreach (data[i]) begin
      expAck = permitted(ptr);
      writeByte(data[i], ack);
      check({tag, " R4/R10 data ack"}, int'(ack), int'(expAck));
      if (!expAck) break;
      refMem[ptr] = data[i];
      modelCur = ptr;
      ptr = (ptr & 'h1FE0) | ((ptr + 1) & 'h1F);
      stored = 1;
    end
    sendStop();
    if (stored) pollReady(tag);
  endtask

  task automatic readSeq(input logic [12:0] addr, input bit random, input int n,
                         input bit relCheck, input string tag);
    logic       ack;
    logic [7:0] d;
    logic       b;
    sendStart();
    if (random) begin
      writeByte(devByte(addr, 1'b0), ack);
      check({tag, " R8 dummy header ack"}, int'(ack), 1);
      writeByte(addr[7:0], ack);
      check({tag, " R8 dummy address ack"}, int'(ack), 1);
      modelCur = int'(addr);
      sendStart();
    end
    writeByte(devByte(addr, 1'b1), ack);
    check({tag, " R3 read header ack"}, int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, d);
      check({tag, " read data"}, int'(d), int'(refMem[modelCur]));
      modelCur = (modelCur + 1) % 8192;
    end
    if (relCheck) begin
      readBit(b);
      check({tag, " R9 line released after NACK"}, int'(b), 1);
    end
    sendStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 released after reset", int'(sdaPullLow), 0);

    // R1: a correct header with no start before it is ignored
    writeByte(devByte(13'h0, 1'b0), ack);
    check("R1 no ack without start", int'(ack), 0);
    sendStop();

    // R3: select matching
    sendStart(); writeByte(8'b1000_0000, ack); sendStop();
    check("R3 select-1 mismatch refused", int'(ack), 0);
    sendStart(); writeByte(8'b0100_0000, ack); sendStop();
    check("R3 select-2 not inverted refused", int'(ack), 0);
    sendStart(); writeByte(devByte(13'h0, 1'b0), ack); sendStop();
    check("R3 matching header accepted", int'(ack), 1);

    // R4 byte write, R6 busy polling
    q.delete(); q.push_back(8'hC3);
    pageWrite(13'h1234, q, "R4");

    // R7 current read ignores header high bits, returns last written byte
    readSeq(13'h1F00, 0, 1, 0, "R7");

    q.delete(); q.push_back(8'hA0); q.push_back(8'hA1);
    pageWrite(13'h1FFE, q, "R4");
    q.delete(); q.push_back(8'hB0); q.push_back(8'hB1); q.push_back(8'hB2);
    pageWrite(13'h0000, q, "R4");

    // R9 sequential read across the top of the address space
    readSeq(13'h1FFE, 1, 5, 1, "R9");
    // R8 random read, then R7 last read plus one (wraps to 0)
    readSeq(13'h1FFF, 1, 1, 0, "R8");
    readSeq(13'h0000, 0, 1, 0, "R7");

    // R5 page wrap: 34 bytes starting two below the page end
    q.delete();
    for (int i = 0; i < 34; i++) q.push_back(8'(8'h10 + i));
    pageWrite(13'h045E, q, "R5");
    readSeq(13'h0000, 0, 1, 0, "R7");
    readSeq(13'h0440, 1, 32, 0, "R5");

    // R10 refused write: no store, no busy
    protOn = 1'b1;
    q.delete(); q.push_back(8'h77);
    pageWrite(13'h1FFE, q, "R10");
    sendStart(); writeByte(devByte(13'h0, 1'b0), ack); sendStop();
    check("R10 no busy after refused write", int'(ack), 1);
    readSeq(13'h1FFE, 1, 1, 0, "R10");
    q.delete(); q.push_back(8'h5A);
    pageWrite(13'h17FF, q, "R10");
    readSeq(13'h17FF, 1, 1, 0, "R10");

    check("R2 drive stable while clock high", r2Viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule